// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a register-programmed SPI master that runs exactly one serial-flash command each time software starts it. Software loads an opcode/address register (opcode byte plus 24-bit flash address), a 32-bit data register holding up to four payload bytes, and a control register that carries a transmit byte count, a receive byte count, an address-present flag and a start bit. Setting the start bit launches a transaction. The engine lowers chip select, shifts out the transmit stream and then clocks in the requested receive bytes, packing them into the data register. A busy flag tells software when the transaction has finished.

The transmit count covers the whole outgoing stream: one opcode byte, then three address bytes when the address-present flag is set, then 0 to 4 payload bytes. Payload and received bytes share the data register, little-endian. Only SPI mode 0 (clock idle low, data sampled on the rising edge) toward a single device is driven. The SCLK half-period is a fixed number of core clock cycles set by a parameter.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset all three registers read zero, chip select is high, SCLK is low and MOSI is low. Register offsets: 0 = opcode/address (opcode in bits 7:0, address in bits 31:8), 1 = data, 2 = control (transmit count bits 3:0, receive count bits 10:8, address-present bit 12, start bit 16 which reads back 0, busy bit 31).
- R2: The transmit stream is the opcode, then (only when address-present is 1) address bits 23:16, 15:8, 7:0, then data bytes 7:0, 15:8, 23:16, 31:24; the first transmit-count bytes of this stream are sent, each byte most significant bit first.
- R3: Receive bytes are clocked in after all transmit bytes; the first received byte lands in data bits 7:0, the next in 15:8, and so on; data bits not received read zero; with a receive count of 0 the data register keeps its value.
- R4: MOSI is low during every receive byte.
- R5: A transaction produces exactly 8 x (transmit count + receive count) rising SCLK edges.
- R6: SCLK is low whenever chip select is high, and MOSI does not change while SCLK is high.
- R7: Chip select rises only after SCLK has already been low for at least one cycle, and it is high whenever the engine is idle.
- R8: The busy bit reads 1 from the cycle after a start write until the transaction ends, then reads 0.
- R9: While busy, a new start request is ignored and writes to any register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench goes after the stream boundaries: commands with and without address bytes, payload lengths of zero and four, and receive counts of one and four, where an engine that mixed up address and payload order or byte endianness would emit wrong MOSI bytes, and one that forgot to zero unreceived bits would leave stale data in the upper bytes. It counts SCLK edges per command, catching an off-by-one in the byte or bit counter as a wrong edge total. It issues a second start and data writes in the cycle right after a start, where an engine that accepted them would restart with new counts or corrupt the payload. It also checks that a command with no receive bytes leaves the data register untouched.

// File: rtl/sfe_pkg.sv
// Shared constants and types for the SPI flash command shift engine.
// Assumes a fixed layout of one opcode byte, three address bytes and a
// four-byte data register.
package sfe_pkg;
    localparam int DATA_BYTES   = 4;
    localparam int ADDR_BYTES   = 3;
    localparam int STREAM_BYTES = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int SIDX_W       = $clog2(STREAM_BYTES);
    localparam int RX_IDX_W     = $clog2(DATA_BYTES);
    localparam int TXC_W        = 4;
    localparam int RXC_W        = 3;
    localparam int REG_AW       = 2;

    localparam logic [REG_AW-1:0] OFS_OPADDR = 2'd0;
    localparam logic [REG_AW-1:0] OFS_DATA   = 2'd1;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 2'd2;

    localparam int TXC_LSB   = 0;
    localparam int RXC_LSB   = 8;
    localparam int AEN_BIT   = 12;
    localparam int START_BIT = 16;
    localparam int BUSY_BIT  = 31;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HI,
        PH_LO,
        PH_TAIL
    } phase_t;
endpackage

// File: rtl/sfe_regs.sv
// Register file: opcode/address, data and control registers, start pulse
// generation and receive-byte packing. Assumes the engine holds busy high
// for the whole transaction; all writes are dropped while busy.
module sfe_regs
    import sfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic                 eng_busy,
    input  logic                 rx_valid,
    input  logic [RX_IDX_W-1:0]  rx_idx,
    input  logic [7:0]           rx_byte,
    output logic                 start,
    output logic [7:0]           opcode,
    output logic [8*ADDR_BYTES-1:0] flash_addr,
    output logic [8*DATA_BYTES-1:0] data_q,
    output logic [TXC_W-1:0]     n_tx,
    output logic [RXC_W-1:0]     n_rx,
    output logic                 addr_en
);
    logic start_q;
    logic busy_all;

    // busy covers the cycle between the start write and the engine launch
    assign busy_all = eng_busy | start_q;
    assign start    = start_q;

    // register writes, start pulse and packing of received bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= 1'b0;
            opcode     <= '0;
            flash_addr <= '0;
            data_q     <= '0;
            n_tx       <= '0;
            n_rx       <= '0;
            addr_en    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_en && !busy_all) begin
                case (addr)
                    OFS_OPADDR: begin
                        opcode     <= wdata[7:0];
                        flash_addr <= wdata[8 +: 8*ADDR_BYTES];
                    end
                    OFS_DATA: data_q <= wdata;
                    OFS_CTRL: begin
                        n_tx    <= wdata[TXC_LSB +: TXC_W];
                        n_rx    <= wdata[RXC_LSB +: RXC_W];
                        addr_en <= wdata[AEN_BIT];
                        start_q <= wdata[START_BIT];
                    end
                    default: ;
                endcase
            end
            if (rx_valid) begin
                if (rx_idx == '0)
                    data_q <= {{(8*DATA_BYTES-8){1'b0}}, rx_byte};
                else
                    data_q[8*rx_idx +: 8] <= rx_byte;
            end
        end
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_OPADDR: rdata = {flash_addr, opcode};
            OFS_DATA:   rdata = data_q;
            OFS_CTRL: begin
                rdata[TXC_LSB +: TXC_W] = n_tx;
                rdata[RXC_LSB +: RXC_W] = n_rx;
                rdata[AEN_BIT]          = addr_en;
                rdata[BUSY_BIT]         = busy_all;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfe_stream.sv
// Transmit stream builder: arranges opcode, optional address bytes (most
// significant first) and payload bytes (least significant first) into a
// byte vector indexed by stream position. Unused tail positions are zero.
module sfe_stream
    import sfe_pkg::*;
(
    input  logic [7:0]                   opcode,
    input  logic [8*ADDR_BYTES-1:0]      flash_addr,
    input  logic [8*DATA_BYTES-1:0]      data_q,
    input  logic                         addr_en,
    output logic [STREAM_BYTES-1:0][7:0] tx_vec
);
    // place each byte at its stream position for the selected layout
    always_comb begin
        tx_vec    = '0;
        tx_vec[0] = opcode;
        for (int i = 0; i < DATA_BYTES; i++) begin
            if (addr_en)
                tx_vec[1 + ADDR_BYTES + i] = data_q[8*i +: 8];
            else
                tx_vec[1 + i] = data_q[8*i +: 8];
        end
        if (addr_en) begin
            for (int j = 0; j < ADDR_BYTES; j++)
                tx_vec[1 + j] = flash_addr[8*(ADDR_BYTES-1-j) +: 8];
        end
    end
endmodule

// File: rtl/sfe_shifter.sv
// Mode-0 SPI bit engine. On start it lowers chip select, waits one
// half-period, then runs 8 bits per byte: MISO is sampled as SCLK rises,
// MOSI advances as SCLK falls. Transmit bytes come first, then receive
// bytes. Chip select rises one half-period after the last falling edge.
// Assumes start only arrives while idle and the stream inputs stay stable.
module sfe_shifter
    import sfe_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [TXC_W-1:0]             n_tx,
    input  logic [RXC_W-1:0]             n_rx,
    input  logic [STREAM_BYTES-1:0][7:0] tx_vec,
    input  logic                         miso,
    output logic                         sclk,
    output logic                         mosi,
    output logic                         cs_n,
    output logic                         busy,
    output logic                         rx_valid,
    output logic [RX_IDX_W-1:0]          rx_idx,
    output logic [7:0]                   rx_byte
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = TXC_W + 1;

    phase_t           phase;
    logic [DIV_W-1:0] div;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_cnt, tx_q, total_q, tx_eff, rx_eff, nxt;
    logic [7:0]       sh, rxsh, nxt_byte;
    logic             tick, in_tx, last_byte;

    // half-period timing and position decode
    always_comb begin
        tick      = (div == DIV_W'(CLK_DIV - 1));
        in_tx     = (byte_cnt < tx_q);
        last_byte = (byte_cnt == total_q - 1'b1);
        nxt       = byte_cnt + 1'b1;
        nxt_byte  = (nxt < CNT_W'(STREAM_BYTES)) ? tx_vec[nxt[SIDX_W-1:0]] : 8'h00;
        tx_eff    = (n_tx == '0) ? CNT_W'(1) : CNT_W'(n_tx);
        rx_eff    = (n_rx > RXC_W'(DATA_BYTES)) ? CNT_W'(DATA_BYTES) : CNT_W'(n_rx);
    end

    // phase sequencing, bit and byte counting, shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            div      <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            tx_q     <= CNT_W'(1);
            total_q  <= CNT_W'(1);
            sh       <= '0;
            rxsh     <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
        end else begin
            if (phase == PH_IDLE || tick) div <= '0;
            else                          div <= div + 1'b1;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cs_n     <= 1'b0;
                        phase    <= PH_LEAD;
                        bit_cnt  <= '0;
                        byte_cnt <= '0;
                        tx_q     <= tx_eff;
                        total_q  <= tx_eff + rx_eff;
                        sh       <= tx_vec[0];
                    end
                end
                PH_LEAD, PH_LO: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rxsh  <= {rxsh[6:0], miso};
                        phase <= PH_HI;
                    end
                end
                PH_HI: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            bit_cnt <= '0;
                            if (last_byte) begin
                                phase <= PH_TAIL;
                            end else begin
                                byte_cnt <= nxt;
                                sh       <= nxt_byte;
                                phase    <= PH_LO;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            sh      <= {sh[6:0], 1'b0};
                            phase   <= PH_LO;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // serial output and receive handoff
    always_comb begin
        mosi     = !cs_n && in_tx && sh[7];
        busy     = (phase != PH_IDLE);
        rx_valid = (phase == PH_HI) && tick && (bit_cnt == 3'd7) && !in_tx;
        rx_idx   = RX_IDX_W'(byte_cnt - tx_q);
        rx_byte  = rxsh;
    end
endmodule

// File: rtl/spi_flash_cmd_engine.sv
// Top of the SPI flash command shift engine: register file, transmit
// stream builder and mode-0 bit engine. One command per start request,
// single device, SCLK half-period of CLK_DIV core cycles.
module spi_flash_cmd_engine
    import sfe_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);
    logic                         start, eng_busy, rx_valid, addr_en;
    logic [RX_IDX_W-1:0]          rx_idx;
    logic [7:0]                   rx_byte, opcode;
    logic [8*ADDR_BYTES-1:0]      flash_addr;
    logic [8*DATA_BYTES-1:0]      data_q;
    logic [TXC_W-1:0]             n_tx;
    logic [RXC_W-1:0]             n_rx;
    logic [STREAM_BYTES-1:0][7:0] tx_vec;

    sfe_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .eng_busy(eng_busy),
        .rx_valid(rx_valid), .rx_idx(rx_idx), .rx_byte(rx_byte),
        .start(start), .opcode(opcode), .flash_addr(flash_addr),
        .data_q(data_q), .n_tx(n_tx), .n_rx(n_rx), .addr_en(addr_en)
    );

    sfe_stream u_stream (
        .opcode(opcode), .flash_addr(flash_addr), .data_q(data_q),
        .addr_en(addr_en), .tx_vec(tx_vec)
    );

    sfe_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .n_tx(n_tx), .n_rx(n_rx),
        .tx_vec(tx_vec), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .cs_n(spi_cs_n), .busy(eng_busy), .rx_valid(rx_valid),
        .rx_idx(rx_idx), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_flash_cmd_engine_chk.sv
// Protocol checker for the SPI flash command shift engine, bound to the top.
module spi_flash_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       mosi,
    input logic       cs_n,
    input logic       eng_busy,
    input logic       rx_valid,
    input logic [1:0] rx_idx,
    input logic [2:0] n_rx
);
    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> cs_n);
    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sclk));
    // R3
    rx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ({1'b0, rx_idx} < n_rx));
endmodule

bind spi_flash_cmd_engine spi_flash_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .eng_busy(eng_busy), .rx_valid(rx_valid),
    .rx_idx(rx_idx), .n_rx(n_rx)
);

// File: tb/spi_flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] slv [12];
    logic [7:0] cap [12];
    int nbits = 0;
    int last_bits = 0;

    always #2.5 clk = ~clk;

    spi_flash_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    // mode-0 flash model: captures MOSI on rising SCLK, drives MISO after falls
    always @(posedge spi_sclk or negedge spi_sclk or posedge spi_cs_n or negedge spi_cs_n) begin
        if (spi_cs_n === 1'b1) begin
            last_bits = nbits;
            nbits = 0;
            spi_miso = 1'b0;
        end else if (spi_sclk === 1'b1) begin
            if (nbits < 96) cap[nbits/8][7 - nbits%8] = spi_mosi;
            nbits++;
        end else begin
            spi_miso = (nbits < 96) ? slv[nbits/8][7 - nbits%8] : 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] exp_tx(input logic [7:0] op, input logic [23:0] a,
                                          input logic [31:0] d, input logic aen, input int i);
        int j;
        if (i == 0) return op;
        if (aen && i <= 3) return a[8*(3-i) +: 8];
        j = aen ? i - 4 : i - 1;
        if (j < 4) return d[8*j +: 8];
        return 8'h00;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] old, input int tx, input int rx);
        logic [31:0] r = '0;
        if (rx == 0) return old;
        for (int k = 0; k < rx; k++) r[8*k +: 8] = slv[tx + k];
        return r;
    endfunction

    function automatic logic [31:0] ctl_word(input int tx, input int rx, input logic aen);
        return (32'd1 << 16) | (32'(aen) << 12) | (32'(rx) << 8) | 32'(tx);
    endfunction

    task automatic wait_idle();
        logic [31:0] r;
        int guard = 0;
        r = 32'h8000_0000;
        while (r[31] && guard < 5000) begin
            reg_read(2'd2, r);
            guard++;
        end
        check("R8", "busy clears", {31'd0, r[31]}, 32'd0);
        @(negedge clk);
    endtask

    task automatic run(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                       input logic aen, input int tx, input int rx);
        logic [31:0] r;
        for (int k = 0; k < 12; k++) slv[k] = 8'($urandom);
        reg_write(2'd0, {a, op});
        reg_write(2'd1, d);
        reg_write(2'd2, ctl_word(tx, rx, aen));
        reg_read(2'd2, r);
        check("R8", "busy after start", {31'd0, r[31]}, 32'd1);
        wait_idle();
        check("R5", "sclk edge count", 32'(last_bits), 32'(8*(tx+rx)));
        for (int i = 0; i < tx; i++)
            check("R2", $sformatf("mosi byte %0d", i), {24'd0, cap[i]}, {24'd0, exp_tx(op, a, d, aen, i)});
        for (int k = 0; k < rx; k++)
            check("R4", $sformatf("mosi during rx byte %0d", k), {24'd0, cap[tx+k]}, 32'd0);
        reg_read(2'd1, r);
        check("R3", "data register", r, exp_data(d, tx, rx));
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 3; a++) begin
            reg_read(2'(a), r);
            check("R1", $sformatf("reg %0d after reset", a), r, 32'd0);
        end
        check("R1", "cs_n idle", {31'd0, spi_cs_n}, 32'd1);
        check("R1", "sclk idle", {31'd0, spi_sclk}, 32'd0);
        check("R1", "mosi idle", {31'd0, spi_mosi}, 32'd0);

        // directed corners: opcode only, status read, 4-byte read, 4-byte payload
        run(8'h06, 24'h000000, 32'hCAFE_F00D, 1'b0, 1, 0);
        run(8'h05, 24'h000000, 32'hFFFF_FFFF, 1'b0, 1, 1);
        run(8'h03, 24'hA1B2C3, 32'h5555_5555, 1'b1, 4, 4);
        run(8'h02, 24'h123456, 32'h8899_AABB, 1'b1, 8, 0);
        run(8'h01, 24'h000000, 32'h0000_00E7, 1'b0, 2, 0);

        // R9 start and register writes while busy are ignored
        reg_write(2'd0, 32'h0000_00AB);
        reg_write(2'd1, 32'h1122_3344);
        reg_write(2'd2, ctl_word(1, 0, 1'b0));
        reg_write(2'd2, ctl_word(8, 4, 1'b1));
        reg_write(2'd1, 32'hDEAD_BEEF);
        reg_write(2'd0, 32'hFFFF_FF99);
        wait_idle();
        check("R9", "edge count with ignored start", 32'(last_bits), 32'd8);
        check("R9", "opcode sent", {24'd0, cap[0]}, 32'h0000_00AB);
        reg_read(2'd1, r);
        check("R9", "data write while busy", r, 32'h1122_3344);
        reg_read(2'd0, r);
        check("R9", "opaddr write while busy", r, 32'h0000_00AB);
        reg_read(2'd2, r);
        check("R9", "control write while busy", r, 32'h0000_0001);

        // constrained random commands (no payload together with receive)
        for (int n = 0; n < 40; n++) begin
            logic aen;
            int pay, rx;
            aen = 1'($urandom);
            pay = int'($urandom % 5);
            rx  = (pay != 0) ? 0 : int'($urandom % 5);
            run(8'($urandom), 24'($urandom), $urandom, aen, 1 + (aen ? 3 : 0) + pay, rx);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL all watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule